// File: doc/BRIEF.md
# Presettable Dual-Strobe BCD Up/Down Digit

This block holds one decimal digit (0 to 9) and moves it by one on each single-cycle strobe. One strobe input steps the digit up and another steps it down, so no direction select is needed. Everything runs on one system clock. A synchronous clear forces the digit to zero. A parallel load writes any 4-bit preset in place of clearing.

Two active-low cascade outputs let digits be chained into a multi-digit up/down counter. One pulses when an up step rolls the digit over from 9 to 0. The other pulses when a down step rolls it under from 0 to 9. Each pulse drives the matching strobe of the next digit up the chain. The modulus and the digit width are parameters. A parameter also selects whether the cascade pulses are registered or combinational.

Top module: `bcd_updown_digit`

## Requirements
- R1: While `rst_n` is low, and after reset is released, `count` is 0 and both `carry_n` and `borrow_n` are 1.
- R2: An up strobe alone (with `dn_stb`, `clr` and `load` low) moves `count` from a value v in 0..8 to v+1 at the next clock edge, and `carry_n` stays 1.
- R3: An up strobe alone while `count` is 9 makes `count` 0 at the next edge, and `carry_n` is 0 for exactly that one following cycle.
- R4: A down strobe alone moves `count` from a value v in 1..9 to v-1 at the next edge, and `borrow_n` stays 1.
- R5: A down strobe alone while `count` is 0 makes `count` 9 at the next edge, and `borrow_n` is 0 for exactly that one following cycle.
- R6: When `up_stb` and `dn_stb` are both high in the same cycle, `count` holds and neither cascade output goes low.
- R7: `load` high with `clr` low places `preset` (any value 0..15) in `count` at the next edge. This overrides both strobes and produces no cascade pulse.
- R8: `clr` high forces `count` to 0 at the next edge, ahead of `load` and both strobes, and produces no cascade pulse.
- R9: With a loaded value in 10..15, an up strobe gives 0 and a down strobe gives 9. Neither produces a cascade pulse.
- R10: With no strobe, no load and no clear, `count` holds its value.
- R11: `carry_n` and `borrow_n` are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear to zero, highest priority |
| load | input | 1 | Synchronous load of `preset` |
| preset | input | 4 | Value written by `load` |
| up_stb | input | 1 | Single-cycle count-up request |
| dn_stb | input | 1 | Single-cycle count-down request |
| count | output | 4 | Current BCD digit |
| carry_n | output | 1 | Active-low rollover pulse on up step from 9 |
| borrow_n | output | 1 | Active-low rollunder pulse on down step from 0 |

## Verification
Every result of this digit is due exactly one rising edge after the cycle in which the strobe, load or clear is presented. With the default registered cascade, this covers both the new `count` and any carry or borrow pulse. The bench drives each stimulus on a falling edge and removes it on the next falling edge. It compares the outputs at that same falling edge, halfway past the one edge that acts on them. A pulse's one-cycle width is confirmed by sampling again one idle cycle later, when the cascade output must be back at 1.

// File: rtl/bcd_digit_pkg.sv
package bcd_digit_pkg;

   typedef enum logic [2:0] {
      ACT_HOLD  = 3'd0,
      ACT_CLEAR = 3'd1,
      ACT_LOAD  = 3'd2,
      ACT_UP    = 3'd3,
      ACT_DOWN  = 3'd4
   } digit_act_e;

endpackage

// File: rtl/bcd_action_sel.sv
// Resolves the control inputs into one action: clear, then load, then count.
module bcd_action_sel
   import bcd_digit_pkg::*;
(
   input  logic       clr,
   input  logic       load,
   input  logic       up_stb,
   input  logic       dn_stb,
   output digit_act_e act
);

   always_comb begin
      if (clr)
         act = ACT_CLEAR;
      else if (load)
         act = ACT_LOAD;
      else if (up_stb && !dn_stb)
         act = ACT_UP;
      else if (dn_stb && !up_stb)
         act = ACT_DOWN;
      else
         act = ACT_HOLD;   // idle, or opposing strobes cancel
   end

endmodule

// File: rtl/bcd_next_calc.sv
// Next-state value and terminal-step detection for one digit.
module bcd_next_calc
   import bcd_digit_pkg::*;
#(
   parameter int DIGIT_W = 4,
   parameter int MODULUS = 10
) (
   input  digit_act_e         act,
   input  logic [DIGIT_W-1:0] cur,
   input  logic [DIGIT_W-1:0] preset,
   output logic [DIGIT_W-1:0] nxt,
   output logic               carry_evt,
   output logic               borrow_evt
);

   localparam logic [DIGIT_W-1:0] TOP_VAL  = DIGIT_W'(MODULUS - 1);
   localparam logic [DIGIT_W-1:0] ZERO_VAL = '0;

   logic at_top, above_top, at_zero;

   assign at_top    = (cur == TOP_VAL);
   assign above_top = (cur >  TOP_VAL);
   assign at_zero   = (cur == ZERO_VAL);

   always_comb begin
      nxt        = cur;
      carry_evt  = 1'b0;
      borrow_evt = 1'b0;
      unique case (act)
         ACT_CLEAR: nxt = ZERO_VAL;
         ACT_LOAD:  nxt = preset;
         ACT_UP: begin
            if (at_top || above_top)
               nxt = ZERO_VAL;
            else
               nxt = cur + DIGIT_W'(1);
            carry_evt = at_top;
         end
         ACT_DOWN: begin
            if (at_zero || above_top)
               nxt = TOP_VAL;
            else
               nxt = cur - DIGIT_W'(1);
            borrow_evt = at_zero;
         end
         default: nxt = cur;
      endcase
   end

endmodule

// File: rtl/bcd_cascade_gen.sv
// Drives the active-low cascade pulses, registered or combinational.
module bcd_cascade_gen #(
   parameter bit REG_CASCADE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic carry_evt,
   input  logic borrow_evt,
   output logic carry_n,
   output logic borrow_n
);

   generate
      if (REG_CASCADE) begin : g_reg
         logic carry_q, borrow_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               carry_q  <= 1'b1;
               borrow_q <= 1'b1;
            end else begin
               carry_q  <= ~carry_evt;
               borrow_q <= ~borrow_evt;
            end
         end
         assign carry_n  = carry_q;
         assign borrow_n = borrow_q;
      end else begin : g_comb
         assign carry_n  = ~carry_evt;
         assign borrow_n = ~borrow_evt;
      end
   endgenerate

endmodule

// File: rtl/bcd_updown_digit.sv
// Presettable BCD digit with separate up and down strobes and cascade pulses.
module bcd_updown_digit
   import bcd_digit_pkg::*;
#(
   parameter int DIGIT_W     = 4,
   parameter int MODULUS     = 10,
   parameter bit REG_CASCADE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               load,
   input  logic [DIGIT_W-1:0] preset,
   input  logic               up_stb,
   input  logic               dn_stb,
   output logic [DIGIT_W-1:0] count,
   output logic               carry_n,
   output logic               borrow_n
);

   generate
      if (MODULUS < 2) begin : g_bad_mod
         $error("bcd_updown_digit: MODULUS must be at least 2");
      end
      if (MODULUS > (1 << DIGIT_W)) begin : g_bad_width
         $error("bcd_updown_digit: MODULUS does not fit in DIGIT_W bits");
      end
   endgenerate

   digit_act_e         act;
   logic [DIGIT_W-1:0] count_q, count_d;
   logic               carry_evt, borrow_evt;

   bcd_action_sel u_sel (
      .clr    (clr),
      .load   (load),
      .up_stb (up_stb),
      .dn_stb (dn_stb),
      .act    (act)
   );

   bcd_next_calc #(
      .DIGIT_W (DIGIT_W),
      .MODULUS (MODULUS)
   ) u_calc (
      .act        (act),
      .cur        (count_q),
      .preset     (preset),
      .nxt        (count_d),
      .carry_evt  (carry_evt),
      .borrow_evt (borrow_evt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count_q <= '0;
      else
         count_q <= count_d;
   end

   bcd_cascade_gen #(
      .REG_CASCADE (REG_CASCADE)
   ) u_casc (
      .clk        (clk),
      .rst_n      (rst_n),
      .carry_evt  (carry_evt),
      .borrow_evt (borrow_evt),
      .carry_n    (carry_n),
      .borrow_n   (borrow_n)
   );

   assign count = count_q;

endmodule

// File: rtl/bcd_updown_digit_chk.sv
module bcd_updown_digit_chk #(
   parameter int DIGIT_W     = 4,
   parameter int MODULUS     = 10,
   parameter bit REG_CASCADE = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               clr,
   input logic               load,
   input logic [DIGIT_W-1:0] preset,
   input logic               up_stb,
   input logic               dn_stb,
   input logic [DIGIT_W-1:0] count,
   input logic               carry_n,
   input logic               borrow_n
);

   localparam logic [DIGIT_W-1:0] TOP_VAL = DIGIT_W'(MODULUS - 1);

   // R8: clear wins and leaves zero
   p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(clr)) |-> (count == '0));

   // R7: load places the preset
   p_load_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(load) && !$past(clr)) |-> (count == $past(preset)));

   // R6: opposing strobes cancel
   p_cancel_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(clr) && !$past(load) && $past(up_stb) && $past(dn_stb))
      |-> $stable(count));

   // R10: idle holds
   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(clr) && !$past(load) && !$past(up_stb) && !$past(dn_stb))
      |-> $stable(count));

   // R3: up step from the top value wraps to zero
   p_up_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(clr) && !$past(load) && $past(up_stb) && !$past(dn_stb)
       && ($past(count) == TOP_VAL)) |-> (count == '0));

   // R5: down step from zero wraps to the top value
   p_down_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(clr) && !$past(load) && $past(dn_stb) && !$past(up_stb)
       && ($past(count) == '0)) |-> (count == TOP_VAL));

   // R11: never both cascade outputs active
   p_cascade_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(!carry_n && !borrow_n));

   generate
      if (REG_CASCADE) begin : g_reg_chk
         // R3: carry pulse follows an up step from the top value
         p_carry_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(clr) && !$past(load) && $past(up_stb) && !$past(dn_stb)
             && ($past(count) == TOP_VAL)) |-> !carry_n);
         // R8: clear never raises a cascade pulse
         p_clear_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(clr)) |-> (carry_n && borrow_n));
         // R3: carry pulse lasts one cycle
         p_carry_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!carry_n) |=> carry_n);
      end
   endgenerate

endmodule

bind bcd_updown_digit bcd_updown_digit_chk #(
   .DIGIT_W     (DIGIT_W),
   .MODULUS     (MODULUS),
   .REG_CASCADE (REG_CASCADE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .clr      (clr),
   .load     (load),
   .preset   (preset),
   .up_stb   (up_stb),
   .dn_stb   (dn_stb),
   .count    (count),
   .carry_n  (carry_n),
   .borrow_n (borrow_n)
);

// File: tb/sim_bcd_updown_digit.sv
`timescale 1ns/1ps
module sim_bcd_updown_digit;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clr = 1'b0, load = 1'b0, up_stb = 1'b0, dn_stb = 1'b0;
   logic [3:0] preset = 4'd0;
   logic [3:0] count;
   logic       carry_n, borrow_n;

   int n_checks = 0;
   int n_fail   = 0;

   always #10 clk = ~clk;   // 50 MHz

   bcd_updown_digit u0 (
      .clk(clk), .rst_n(rst_n), .clr(clr), .load(load), .preset(preset),
      .up_stb(up_stb), .dn_stb(dn_stb),
      .count(count), .carry_n(carry_n), .borrow_n(borrow_n)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Present inputs at a falling edge for one cycle; return at the next falling edge.
   task automatic step(input logic c, input logic l, input logic [3:0] p,
                       input logic u, input logic d);
      clr = c; load = l; preset = p; up_stb = u; dn_stb = d;
      @(negedge clk);
      clr = 1'b0; load = 1'b0; up_stb = 1'b0; dn_stb = 1'b0;
   endtask

   task automatic t_reset();
      check("R1", "count in reset", count, 0);
      check("R1", "carry_n in reset", carry_n, 1);
      check("R1", "borrow_n in reset", borrow_n, 1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "count after reset", count, 0);
      check("R1", "borrow_n after reset", borrow_n, 1);
   endtask

   task automatic t_count_up();
      step(1'b1, 1'b0, 4'd0, 1'b0, 1'b0);
      for (int v = 0; v < 9; v++) begin
         step(1'b0, 1'b0, 4'd0, 1'b1, 1'b0);
         check("R2", "up count", count, v + 1);
         check("R2", "carry_n mid-range", carry_n, 1);
      end
      step(1'b0, 1'b0, 4'd0, 1'b1, 1'b0);
      check("R3", "up wrap count", count, 0);
      check("R3", "carry_n on wrap", carry_n, 0);
      check("R11", "borrow_n on carry", borrow_n, 1);
      step(1'b0, 1'b0, 4'd0, 1'b0, 1'b0);
      check("R3", "carry_n one cycle", carry_n, 1);
   endtask

   task automatic t_count_down();
      step(1'b0, 1'b1, 4'd9, 1'b0, 1'b0);
      for (int v = 9; v > 0; v--) begin
         step(1'b0, 1'b0, 4'd0, 1'b0, 1'b1);
         check("R4", "down count", count, v - 1);
         check("R4", "borrow_n mid-range", borrow_n, 1);
      end
      step(1'b0, 1'b0, 4'd0, 1'b0, 1'b1);
      check("R5", "down wrap count", count, 9);
      check("R5", "borrow_n on wrap", borrow_n, 0);
      check("R11", "carry_n on borrow", carry_n, 1);
      step(1'b0, 1'b0, 4'd0, 1'b0, 1'b0);
      check("R5", "borrow_n one cycle", borrow_n, 1);
   endtask

   task automatic t_cancel();
      step(1'b0, 1'b1, 4'd9, 1'b0, 1'b0);
      step(1'b0, 1'b0, 4'd0, 1'b1, 1'b1);
      check("R6", "both strobes at 9", count, 9);
      check("R6", "carry_n both strobes", carry_n, 1);
      step(1'b0, 1'b1, 4'd0, 1'b0, 1'b0);
      step(1'b0, 1'b0, 4'd0, 1'b1, 1'b1);
      check("R6", "both strobes at 0", count, 0);
      check("R6", "borrow_n both strobes", borrow_n, 1);
   endtask

   task automatic t_load();
      step(1'b0, 1'b1, 4'd6, 1'b0, 1'b0);
      check("R7", "load 6", count, 6);
      step(1'b0, 1'b1, 4'd3, 1'b1, 1'b0);
      check("R7", "load beats up", count, 3);
      step(1'b0, 1'b1, 4'd9, 1'b0, 1'b1);
      check("R7", "load beats down", count, 9);
      step(1'b0, 1'b1, 4'd0, 1'b1, 1'b0);
      check("R7", "load beats up at 9", count, 0);
      check("R7", "no carry on load", carry_n, 1);
   endtask

   task automatic t_clear();
      step(1'b0, 1'b1, 4'd7, 1'b0, 1'b0);
      step(1'b1, 1'b1, 4'd5, 1'b1, 1'b0);
      check("R8", "clear beats load", count, 0);
      step(1'b1, 1'b0, 4'd0, 1'b0, 1'b1);
      check("R8", "clear at 0 with down", count, 0);
      check("R8", "no borrow on clear", borrow_n, 1);
      step(1'b0, 1'b1, 4'd9, 1'b0, 1'b0);
      step(1'b1, 1'b0, 4'd0, 1'b1, 1'b0);
      check("R8", "clear at 9 with up", count, 0);
      check("R8", "no carry on clear", carry_n, 1);
   endtask

   task automatic t_out_of_range();
      step(1'b0, 1'b1, 4'd12, 1'b0, 1'b0);
      check("R7", "load 12", count, 12);
      step(1'b0, 1'b0, 4'd0, 1'b1, 1'b0);
      check("R9", "12 up", count, 0);
      check("R9", "no carry from 12", carry_n, 1);
      step(1'b0, 1'b1, 4'd15, 1'b0, 1'b0);
      step(1'b0, 1'b0, 4'd0, 1'b0, 1'b1);
      check("R9", "15 down", count, 9);
      check("R9", "no borrow from 15", borrow_n, 1);
      step(1'b0, 1'b1, 4'd10, 1'b0, 1'b0);
      step(1'b0, 1'b0, 4'd0, 1'b0, 1'b1);
      check("R9", "10 down", count, 9);
   endtask

   task automatic t_idle();
      step(1'b0, 1'b1, 4'd4, 1'b0, 1'b0);
      for (int i = 0; i < 3; i++) begin
         step(1'b0, 1'b0, 4'd11, 1'b0, 1'b0);
         check("R10", "idle hold", count, 4);
      end
   endtask

   initial begin
      #4_000_000;
      n_checks++;
      n_fail++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      t_reset();
      t_count_up();
      t_count_down();
      t_cancel();
      t_load();
      t_clear();
      t_out_of_range();
      t_idle();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule